// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address. It reads two levels of translation tables held in memory, each a 4 KiB page of 512 descriptors that are 64 bits wide. A caller offers a virtual address together with the base of the first table, and the walker accepts it when `start_ready` is high. It then reads the level-2 descriptor through a single-word memory request/response port. That descriptor names the level-3 table. The walker reads the level-3 descriptor next, and that one names the 4 KiB frame. The final address joins the frame number to the untouched 12-bit page offset.

A descriptor is usable only when its valid bit (bit 0) and its table/page bit (bit 1) are both set. When either is clear, the walk stops and reports which level failed. A virtual address that uses any bit above bit 29 lies outside the two-level span, so it is refused before any memory read. Each walk ends with a one-cycle `done_valid` pulse. The pulse carries the physical address, the page attribute fields taken from the level-3 descriptor, and a fault code.

Top module: `ptw_walker`

## Requirements
- R1: After reset `start_ready` is 1, and `done_valid` and `mem_req_valid` are 0.
- R2: The first memory request of a walk reads address `{ttbr_base[47:12], 12'h000} + va[29:21]*8`, which is always a multiple of 8.
- R3: The second request reads `{D2[47:12], 12'h000} + va[20:12]*8`, where D2 is the level-2 descriptor. It is issued only when D2 has bit 0 and bit 1 both set.
- R4: A successful walk returns `done_pa = {D3[47:12], va[11:0]}`, where D3 is the level-3 descriptor. For example, va 0x001F_F030 with D3[47:12] = 0x3F201 gives 0x3F201030.
- R5: A successful walk reports the fields of D3 as follows: `done_attr_idx` = D3[4:2], `done_ap` = D3[7:6], `done_sh` = D3[9:8], `done_af` = D3[10] and `done_pxn` = D3[53]. `done_fault` is 0 and `done_fault_code` is 0.
- R6: If D2 has bit 0 or bit 1 clear, the walk ends with `done_fault` = 1 and `done_fault_code` = 2, and no level-3 request is made.
- R7: If D3 has bit 0 or bit 1 clear, the walk ends with `done_fault` = 1 and `done_fault_code` = 3.
- R8: If any bit of va above bit 29 is set, the walk ends in the cycle after acceptance with `done_fault` = 1 and `done_fault_code` = 1, and no memory request is made.
- R9: At most one memory request is outstanding. A request that has not been accepted keeps `mem_req_valid` high and `mem_req_addr` unchanged.
- R10: `done_valid` is high for exactly one cycle per walk. On a faulted walk, `done_pa` and all attribute outputs are 0.
- R11: While a walk is in progress `start_ready` is 0, and a `start_valid` in that time is ignored: the walk in progress finishes with its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Caller offers a virtual address |
| start_ready | output | 1 | Walker is idle and accepts a new address |
| start_va | input | VA_W | Virtual address to translate |
| ttbr_base | input | 48 | Base of the level-2 table, sampled at acceptance |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data is present |
| mem_rsp_data | input | 64 | Descriptor returned by memory |
| done_valid | output | 1 | One-cycle result pulse |
| done_pa | output | 48 | Physical address |
| done_attr_idx | output | 3 | Memory attribute index |
| done_ap | output | 2 | Access permission field |
| done_sh | output | 2 | Shareability field |
| done_af | output | 1 | Access flag |
| done_pxn | output | 1 | Privileged execute-never |
| done_fault | output | 1 | Walk failed |
| done_fault_code | output | 2 | 0 none, 1 address out of range, 2 level-2 fault, 3 level-3 fault |

## Verification
A wrong sequencer state shows up at the memory port within one request. There are three ways it can appear: a missing second read, an extra read after a level-2 fault, or a read whose address uses the wrong index bits or base. The bench records every request address and counts the requests in each walk. A stale or misrouted captured register, such as the base, the offset or a descriptor field, reaches the ports only at the `done_valid` pulse. That pulse is compared field by field against an independently computed result. Random ready and response latencies expose any dependence on fixed timing at once. A start pulse offered mid-walk shows whether the busy window leaks.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PA_W      = 48;
  localparam int DESC_W    = 64;
  localparam int OFS_W     = 12;
  localparam int IDX_W     = 9;
  localparam int ENT_SHIFT = 3;
  localparam int VA_SPAN   = OFS_W + 2 * IDX_W;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_FETCH_L2 = 2'd1,
    ST_FETCH_L3 = 2'd2,
    ST_DONE     = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_RANGE = 2'd1,
    FLT_L2    = 2'd2,
    FLT_L3    = 2'd3
  } fault_code_e;

  typedef struct packed {
    logic       pxn;
    logic       af;
    logic [1:0] sh;
    logic [1:0] ap;
    logic [2:0] attr_idx;
  } pte_attr_t;

  // Clears the in-page bits so the value names a 4 KiB aligned frame.
  function automatic logic [PA_W-1:0] frame_base(input logic [PA_W-1:0] raw);
    return {raw[PA_W-1:OFS_W], {OFS_W{1'b0}}};
  endfunction

  // Byte address of descriptor number idx inside the table at table_base.
  function automatic logic [PA_W-1:0] entry_addr(input logic [PA_W-1:0] table_base,
                                                 input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] scaled;
    scaled = PA_W'({idx, {ENT_SHIFT{1'b0}}});
    return frame_base(table_base) + scaled;
  endfunction

  function automatic logic [IDX_W-1:0] l2_index(input logic [VA_SPAN-1:0] va);
    return va[VA_SPAN-1 -: IDX_W];
  endfunction

  function automatic logic [IDX_W-1:0] l3_index(input logic [VA_SPAN-1:0] va);
    return va[OFS_W +: IDX_W];
  endfunction

  function automatic logic [PA_W-1:0] join_pa(input logic [PA_W-1:0] frame,
                                              input logic [VA_SPAN-1:0] va);
    return {frame[PA_W-1:OFS_W], va[OFS_W-1:0]};
  endfunction
endpackage

// File: rtl/ptw_desc_decode.sv
module ptw_desc_decode
  import ptw_pkg::*;
(
  input  logic [DESC_W-1:0] desc,
  output logic              is_table,
  output logic [PA_W-1:0]   next_base,
  output pte_attr_t         attr
);
  localparam int BIT_VALID = 0;
  localparam int BIT_TYPE  = 1;
  localparam int AIDX_LO   = 2;
  localparam int AP_LO     = 6;
  localparam int SH_LO     = 8;
  localparam int BIT_AF    = 10;
  localparam int BIT_PXN   = 53;

  assign is_table  = desc[BIT_VALID] & desc[BIT_TYPE];
  assign next_base = frame_base(desc[PA_W-1:0]);

  always_comb begin
    attr.attr_idx = desc[AIDX_LO +: 3];
    attr.ap       = desc[AP_LO +: 2];
    attr.sh       = desc[SH_LO +: 2];
    attr.af       = desc[BIT_AF];
    attr.pxn      = desc[BIT_PXN];
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic               sel_l3,
  input  logic [VA_SPAN-1:0] va_low,
  input  logic [PA_W-1:0]    root_base,
  input  logic [PA_W-1:0]    l3_base,
  output logic [PA_W-1:0]    fetch_addr
);
  always_comb begin
    if (sel_l3) fetch_addr = entry_addr(l3_base, l3_index(va_low));
    else        fetch_addr = entry_addr(root_base, l2_index(va_low));
  end
endmodule

// File: rtl/ptw_seq.sv
module ptw_seq
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_valid,
  input  logic [VA_SPAN-1:0] start_va_low,
  input  logic               start_out_of_range,
  input  logic [PA_W-1:0]    ttbr_base,
  output logic               start_ready,
  input  logic               mem_req_ready,
  input  logic               mem_rsp_valid,
  input  logic               desc_is_table,
  input  logic [PA_W-1:0]    desc_next_base,
  input  pte_attr_t          desc_attr,
  output logic               mem_req_valid,
  output logic               sel_l3,
  output logic [VA_SPAN-1:0] va_q,
  output logic [PA_W-1:0]    root_q,
  output logic [PA_W-1:0]    l3_base_q,
  output logic               done_valid,
  output logic [PA_W-1:0]    done_pa,
  output pte_attr_t          done_attr,
  output fault_code_e        done_code,
  output walk_state_e        state,
  output logic               start_fire,
  output logic               req_fire,
  output logic               rsp_take,
  output logic               range_reject
);
  logic      issued;
  logic      fetching;

  assign fetching      = (state == ST_FETCH_L2) || (state == ST_FETCH_L3);
  assign start_ready   = (state == ST_IDLE);
  assign start_fire    = start_ready && start_valid;
  assign range_reject  = start_fire && start_out_of_range;
  assign mem_req_valid = fetching && !issued;
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_take      = fetching && issued && mem_rsp_valid;
  assign sel_l3        = (state == ST_FETCH_L3);
  assign done_valid    = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      issued    <= 1'b0;
      va_q      <= '0;
      root_q    <= '0;
      l3_base_q <= '0;
      done_pa   <= '0;
      done_attr <= '0;
      done_code <= FLT_NONE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start_fire) begin
            va_q      <= start_va_low;
            root_q    <= frame_base(ttbr_base);
            issued    <= 1'b0;
            done_pa   <= '0;
            done_attr <= '0;
            if (start_out_of_range) begin
              done_code <= FLT_RANGE;
              state     <= ST_DONE;
            end else begin
              done_code <= FLT_NONE;
              state     <= ST_FETCH_L2;
            end
          end
        end
        ST_FETCH_L2: begin
          if (req_fire) issued <= 1'b1;
          if (rsp_take) begin
            issued <= 1'b0;
            if (desc_is_table) begin
              l3_base_q <= desc_next_base;
              state     <= ST_FETCH_L3;
            end else begin
              done_code <= FLT_L2;
              state     <= ST_DONE;
            end
          end
        end
        ST_FETCH_L3: begin
          if (req_fire) issued <= 1'b1;
          if (rsp_take) begin
            issued <= 1'b0;
            state  <= ST_DONE;
            if (desc_is_table) begin
              done_pa   <= join_pa(desc_next_base, va_q);
              done_attr <= desc_attr;
              done_code <= FLT_NONE;
            end else begin
              done_code <= FLT_L3;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
#(
  parameter int VA_W = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [VA_W-1:0]   start_va,
  input  logic [PA_W-1:0]   ttbr_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [DESC_W-1:0] mem_rsp_data,
  output logic              done_valid,
  output logic [PA_W-1:0]   done_pa,
  output logic [2:0]        done_attr_idx,
  output logic [1:0]        done_ap,
  output logic [1:0]        done_sh,
  output logic              done_af,
  output logic              done_pxn,
  output logic              done_fault,
  output logic [1:0]        done_fault_code
);
  logic [VA_SPAN-1:0] start_va_low;
  logic               start_out_of_range;

  generate
    if (VA_W > VA_SPAN) begin : g_range
      assign start_va_low       = start_va[VA_SPAN-1:0];
      assign start_out_of_range = |start_va[VA_W-1:VA_SPAN];
    end else begin : g_norange
      assign start_va_low       = VA_SPAN'(start_va);
      assign start_out_of_range = 1'b0;
    end
  endgenerate

  logic               desc_is_table;
  logic [PA_W-1:0]    desc_next_base;
  pte_attr_t          desc_attr;
  logic               sel_l3;
  logic [VA_SPAN-1:0] va_q;
  logic [PA_W-1:0]    root_q;
  logic [PA_W-1:0]    l3_base_q;
  pte_attr_t          done_attr;
  fault_code_e        done_code;
  walk_state_e        state;
  logic               start_fire;
  logic               req_fire;
  logic               rsp_take;
  logic               range_reject;

  ptw_desc_decode u_dec (
    .desc      (mem_rsp_data),
    .is_table  (desc_is_table),
    .next_base (desc_next_base),
    .attr      (desc_attr)
  );

  ptw_addr_gen u_addr (
    .sel_l3     (sel_l3),
    .va_low     (va_q),
    .root_base  (root_q),
    .l3_base    (l3_base_q),
    .fetch_addr (mem_req_addr)
  );

  ptw_seq u_seq (
    .clk                (clk),
    .rst_n              (rst_n),
    .start_valid        (start_valid),
    .start_va_low       (start_va_low),
    .start_out_of_range (start_out_of_range),
    .ttbr_base          (ttbr_base),
    .start_ready        (start_ready),
    .mem_req_ready      (mem_req_ready),
    .mem_rsp_valid      (mem_rsp_valid),
    .desc_is_table      (desc_is_table),
    .desc_next_base     (desc_next_base),
    .desc_attr          (desc_attr),
    .mem_req_valid      (mem_req_valid),
    .sel_l3             (sel_l3),
    .va_q               (va_q),
    .root_q             (root_q),
    .l3_base_q          (l3_base_q),
    .done_valid         (done_valid),
    .done_pa            (done_pa),
    .done_attr          (done_attr),
    .done_code          (done_code),
    .state              (state),
    .start_fire         (start_fire),
    .req_fire           (req_fire),
    .rsp_take           (rsp_take),
    .range_reject       (range_reject)
  );

  assign done_attr_idx   = done_attr.attr_idx;
  assign done_ap         = done_attr.ap;
  assign done_sh         = done_attr.sh;
  assign done_af         = done_attr.af;
  assign done_pxn        = done_attr.pxn;
  assign done_fault_code = done_code;
  assign done_fault      = (done_code != FLT_NONE);
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk
  import ptw_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            start_ready,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [PA_W-1:0] mem_req_addr,
  input logic            done_valid,
  input logic [PA_W-1:0] done_pa,
  input logic            done_fault,
  input logic [1:0]      done_fault_code,
  input logic            desc_is_table,
  input logic            req_fire,
  input logic            rsp_take,
  input logic            range_reject,
  input walk_state_e     state
);
  logic [1:0] outst;

  always_ff @(posedge clk) begin
    if (!rst_n) outst <= '0;
    else if (req_fire && !rsp_take) outst <= outst + 2'd1;
    else if (rsp_take && !req_fire) outst <= outst - 2'd1;
  end

  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000)); // R2

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> (outst == 2'd0)); // R9

  AST_RSP_MATCHES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_take |-> (outst == 2'd1)); // R9

  AST_L2_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && state == ST_FETCH_L2 && !desc_is_table) |=>
      (done_valid && done_fault_code == 2'd2 && !mem_req_valid)); // R6

  AST_L3_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && state == ST_FETCH_L3 && !desc_is_table) |=>
      (done_valid && done_fault && done_fault_code == 2'd3)); // R7

  AST_RANGE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    range_reject |=> (done_valid && done_fault_code == 2'd1 && !mem_req_valid)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid); // R10

  AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_fault) |-> (done_pa == '0)); // R10

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !start_ready); // R11
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .start_ready     (start_ready),
  .mem_req_valid   (mem_req_valid),
  .mem_req_ready   (mem_req_ready),
  .mem_req_addr    (mem_req_addr),
  .done_valid      (done_valid),
  .done_pa         (done_pa),
  .done_fault      (done_fault),
  .done_fault_code (done_fault_code),
  .desc_is_table   (desc_is_table),
  .req_fire        (req_fire),
  .rsp_take        (rsp_take),
  .range_reject    (range_reject),
  .state           (state)
);

// File: tb/ptw_walker_test.sv
module ptw_walker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [47:0] start_va = '0;
  logic [47:0] ttbr_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        done_valid;
  logic [47:0] done_pa;
  logic [2:0]  done_attr_idx;
  logic [1:0]  done_ap;
  logic [1:0]  done_sh;
  logic        done_af;
  logic        done_pxn;
  logic        done_fault;
  logic [1:0]  done_fault_code;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // memory model state
  logic [63:0] l2_desc, l3_desc;
  logic [47:0] req_addr [2];
  int          nreq;
  logic        pend = 1'b0;
  int          lat = 0;
  logic [63:0] pend_data = '0;
  logic        rand_ready = 1'b1;

  ptw_walker #(.VA_W(48)) uut (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
    .start_va(start_va), .ttbr_base(ttbr_base), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done_valid(done_valid), .done_pa(done_pa), .done_attr_idx(done_attr_idx),
    .done_ap(done_ap), .done_sh(done_sh), .done_af(done_af), .done_pxn(done_pxn),
    .done_fault(done_fault), .done_fault_code(done_fault_code)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // bench-side restatement of the walk arithmetic
  function automatic logic [47:0] exp_slot(input logic [47:0] tbl, input int idx);
    logic [47:0] b;
    b = tbl & ~48'hFFF;
    return b + 48'(idx * 8);
  endfunction

  function automatic bit desc_ok(input logic [63:0] d);
    return d[0] == 1'b1 && d[1] == 1'b1;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = pend_data;
          pend = 1'b0;
        end else lat--;
      end
      mem_req_ready = rand_ready ? ($urandom_range(0, 3) != 0) : 1'b1;
      #1;
      if (mem_req_valid && mem_req_ready) begin
        if (nreq < 2) req_addr[nreq] = mem_req_addr;
        pend_data = (nreq == 0) ? l2_desc : l3_desc;
        nreq++;
        pend = 1'b1;
        lat  = rand_ready ? $urandom_range(0, 3) : 0;
      end
    end
  end

  task automatic walk(input logic [47:0] va, input logic [47:0] tb,
                      input logic [63:0] d2, input logic [63:0] d3, input bit busy_poke);
    bit range_bad;
    int exp_code, exp_nreq, waited;
    logic [47:0] exp_pa;
    range_bad = (va[47:30] != 0);
    if (range_bad) begin exp_code = 1; exp_nreq = 0; end
    else if (!desc_ok(d2)) begin exp_code = 2; exp_nreq = 1; end
    else if (!desc_ok(d3)) begin exp_code = 3; exp_nreq = 2; end
    else begin exp_code = 0; exp_nreq = 2; end
    exp_pa = (exp_code == 0) ? {d3[47:12], va[11:0]} : 48'h0;

    l2_desc = d2; l3_desc = d3; nreq = 0;
    @(negedge clk);
    start_valid = 1'b1; start_va = va; ttbr_base = tb;
    @(negedge clk);
    start_valid = 1'b0;
    if (busy_poke && !range_bad) begin
      // R11: offer another address while busy
      chk(start_ready == 1'b0, "R11 start_ready busy", 64'(start_ready), 64'd0);
      start_valid = 1'b1; start_va = va ^ 48'h0000_0FFF_F555; ttbr_base = tb ^ 48'h1000;
      @(negedge clk);
      start_valid = 1'b0; start_va = va; ttbr_base = tb;
    end
    waited = 0;
    while (!done_valid && waited < 200) begin
      @(negedge clk);
      waited++;
    end
    chk(done_valid == 1'b1, "R10 done seen", 64'(done_valid), 64'd1);
    chk(done_fault_code == 2'(exp_code), exp_code == 1 ? "R8 fault code" :
        exp_code == 2 ? "R6 fault code" : exp_code == 3 ? "R7 fault code" : "R5 fault code",
        64'(done_fault_code), 64'(exp_code));
    chk(done_fault == (exp_code != 0), "R5 fault flag", 64'(done_fault), 64'(exp_code != 0));
    chk(done_pa == exp_pa, "R4 physical address", 64'(done_pa), 64'(exp_pa));
    if (exp_code == 0) begin
      chk({done_pxn, done_af, done_sh, done_ap, done_attr_idx} ==
          {d3[53], d3[10], d3[9:8], d3[7:6], d3[4:2]}, "R5 attributes",
          64'({done_pxn, done_af, done_sh, done_ap, done_attr_idx}),
          64'({d3[53], d3[10], d3[9:8], d3[7:6], d3[4:2]}));
    end else begin
      chk({done_pxn, done_af, done_sh, done_ap, done_attr_idx} == 9'h0, "R10 fault attrs zero",
          64'({done_pxn, done_af, done_sh, done_ap, done_attr_idx}), 64'd0);
    end
    chk(nreq == exp_nreq, exp_code == 1 ? "R8 request count" : "R3 request count",
        64'(nreq), 64'(exp_nreq));
    if (exp_nreq >= 1)
      chk(req_addr[0] == exp_slot(tb, int'(va[29:21])), "R2 level-2 address",
          64'(req_addr[0]), 64'(exp_slot(tb, int'(va[29:21]))));
    if (exp_nreq == 2)
      chk(req_addr[1] == exp_slot(d2[47:0], int'(va[20:12])), "R3 level-3 address",
          64'(req_addr[1]), 64'(exp_slot(d2[47:0], int'(va[20:12]))));
    @(negedge clk);
    chk(done_valid == 1'b0, "R10 single pulse", 64'(done_valid), 64'd0);
    chk(start_ready == 1'b1, "R11 ready after walk", 64'(start_ready), 64'd1);
  endtask

  function automatic logic [63:0] rand_desc(input bit force_ok);
    logic [63:0] d;
    d = {$urandom, $urandom};
    d[63:48] = '0;
    d[53] = $urandom_range(0, 1);
    if (force_ok || $urandom_range(0, 7) != 0) d[1:0] = 2'b11;
    else d[1:0] = 2'($urandom_range(0, 2));
    return d;
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(start_ready == 1'b1, "R1 start_ready", 64'(start_ready), 64'd1);
    chk(done_valid == 1'b0, "R1 done_valid", 64'(done_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    // R4: worked example, L2 entry 0, L3 entry 511
    rand_ready = 1'b0;
    walk(48'h0000_001F_F030, 48'h0000_0008_0000, 64'h0000_0000_0009_0003,
         64'h0020_0000_3F20_1747, 1'b0);
    // R6: level-2 invalid and level-2 block-type
    walk(48'h0000_2345_6789, 48'h0000_1234_5000, 64'h0000_0000_0009_0002, 64'h3, 1'b0);
    walk(48'h0000_2345_6789, 48'h0000_1234_5000, 64'h0000_0000_0009_0001, 64'h3, 1'b0);
    // R7: level-3 type bit clear
    walk(48'h0000_0000_0ABC, 48'h0000_0000_1000, 64'h0000_0000_0002_0003,
         64'h0000_0000_7777_7001, 1'b0);
    // R8: bit 30 and bit 47 set
    walk(48'h0000_4000_0000, 48'h0, 64'h3, 64'h3, 1'b0);
    walk(48'h8000_0000_0000, 48'h0, 64'h3, 64'h3, 1'b0);
    // max indices, unaligned ttbr bits ignored
    walk(48'h0000_3FFF_FFFF, 48'hFFFF_FFFF_FABC, 64'h0000_FFFF_FFFF_F003,
         64'h0020_FFFF_FFFF_FFFF, 1'b1);

    rand_ready = 1'b1;
    for (int i = 0; i < 60; i++) begin
      logic [47:0] va;
      va = {$urandom, $urandom} & 48'h0000_3FFF_FFFF;
      if ($urandom_range(0, 9) == 0) va[30 + $urandom_range(0, 17)] = 1'b1;
      walk(va, {$urandom, $urandom}, rand_desc(1'b0), rand_desc(1'b0), (i % 3) == 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule